// File: doc/BRIEF.md
# E1 Loopback Path Selector

This block sits between the line side of a 32-timeslot E1 framer and a serial PCM bus on the system side. One timeslot byte arrives per strobe, with its timeslot number and a pulse that marks timeslot 0 of each frame. For each timeslot the block picks the byte sent toward the line transmitter and the byte sent out on the system bus. The sources are the received line byte, the system bus input byte and a byte from a separate framing generator.

Three control bits select the routing. Payload loopback returns the received traffic toward the line in place of the system bus input, and the framing generator supplies timeslot 0 at the loop point. Remote timeslot loopback returns only the 30 payload timeslots toward the line. Local timeslot loopback returns system bus input payload timeslots on the system bus output.

The active configuration is a registered state. It changes only on the frame-start strobe, so no frame is built from two configurations. The states are ST_NORM, ST_RMT, ST_LCL, ST_RMT_LCL, ST_PLB and ST_PLB_LCL. There is one transition, taken on every frame-start strobe: the state moves to the one decoded from the three control bits, and payload loopback overrides remote loopback. Without a frame-start strobe the state holds. Reset enters ST_NORM.

Top module: `e1_loop_sel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_stb is 0 and line_tx_byte and bus_out_byte are 0.
- R2: A strobe with timeslot number N produces out_stb = 1 with out_num = N one clock later.
- R3: In normal mode, line_tx_byte for timeslots 1 to 31 equals bus_in_byte, and bus_out_byte for every timeslot equals line_rx_byte.
- R4: For timeslot 0, line_tx_byte always equals fgen_byte, in every mode.
- R5: With remote loopback active, line_tx_byte for timeslots 1 to 15 and 17 to 31 equals line_rx_byte, and timeslot 16 keeps bus_in_byte.
- R6: With local loopback active, bus_out_byte for timeslots 1 to 15 and 17 to 31 equals bus_in_byte. Timeslots 0 and 16 always carry line_rx_byte on bus_out_byte.
- R7: With payload loopback active, line_tx_byte for timeslots 1 to 31, including timeslot 16, equals line_rx_byte. It overrides remote loopback where both are set.
- R8: The control bits are sampled only on a strobe with frm_sync = 1. That sample applies from that timeslot to the next frame start, and control changes in between have no effect.
- R9: After reset, until the first frame-start strobe, routing is normal whatever the control bits are.
- R10: A cycle without a strobe gives out_stb = 0 and leaves both output bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_stb | input | 1 | One timeslot byte is present |
| ts_num | input | 5 | Timeslot number of the byte |
| frm_sync | input | 1 | Marks timeslot 0, the frame boundary |
| cfg_payload_lb | input | 1 | Payload loopback request (1 = active) |
| cfg_remote_lb | input | 1 | Remote timeslot loopback request (1 = active) |
| cfg_local_lb | input | 1 | Local timeslot loopback request (1 = active) |
| line_rx_byte | input | 8 | Byte received from the line |
| bus_in_byte | input | 8 | Byte from the system bus input |
| fgen_byte | input | 8 | Timeslot 0 byte from the framing generator |
| line_tx_byte | output | 8 | Byte toward the line transmitter |
| bus_out_byte | output | 8 | Byte onto the system bus output |
| out_stb | output | 1 | Output bytes are valid |
| out_num | output | 5 | Timeslot number of the output bytes |

## Verification
Each routed byte, with out_stb and out_num, is due exactly one clock after its strobe, because it passes through one output register. The bench drives each strobe on a falling edge and compares against its own model on the next falling edge, before it drives the next strobe. A new configuration affects the frame-start timeslot itself, since the bench model takes the control bits on that same strobe. Mid-frame control changes and idle cycles are checked the same way, one clock after they are applied.

// File: rtl/e1lb_pkg.sv
package e1lb_pkg;

    typedef enum logic [2:0] {
        ST_NORM    = 3'd0,
        ST_RMT     = 3'd1,
        ST_LCL     = 3'd2,
        ST_RMT_LCL = 3'd3,
        ST_PLB     = 3'd4,
        ST_PLB_LCL = 3'd5
    } lb_state_e;

    typedef struct packed {
        logic payload;
        logic remote;
        logic local_;
    } lb_sel_t;

    function automatic lb_state_e decode_cfg(input logic plb, input logic rmt, input logic lcl);
        if (plb)
            return lcl ? ST_PLB_LCL : ST_PLB;
        else if (rmt)
            return lcl ? ST_RMT_LCL : ST_RMT;
        else
            return lcl ? ST_LCL : ST_NORM;
    endfunction

endpackage

// File: rtl/e1lb_mode_fsm.sv
module e1lb_mode_fsm
    import e1lb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      boundary,
    input  logic      cfg_plb,
    input  logic      cfg_rmt,
    input  logic      cfg_lcl,
    output lb_state_e state_q,
    output lb_sel_t   sel
);
    lb_state_e state_d;
    lb_state_e state_eff;

    always_comb begin
        state_d = boundary ? decode_cfg(cfg_plb, cfg_rmt, cfg_lcl) : state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_NORM;
        else
            state_q <= state_d;
    end

    // the frame-start timeslot already follows the new configuration
    assign state_eff = state_d;

    always_comb begin
        sel = '0;
        unique case (state_eff)
            ST_NORM:    sel = '0;
            ST_RMT:     sel.remote  = 1'b1;
            ST_LCL:     sel.local_  = 1'b1;
            ST_RMT_LCL: begin
                sel.remote = 1'b1;
                sel.local_ = 1'b1;
            end
            ST_PLB:     sel.payload = 1'b1;
            ST_PLB_LCL: begin
                sel.payload = 1'b1;
                sel.local_  = 1'b1;
            end
            default:    sel = '0;
        endcase
    end
endmodule

// File: rtl/e1lb_route.sv
module e1lb_route
    import e1lb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SLOT_W   = 5,
    parameter int SIG_SLOT = 16
) (
    input  logic [SLOT_W-1:0] slot,
    input  lb_sel_t           sel,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] bin_byte,
    input  logic [DATA_W-1:0] fg_byte,
    output logic [DATA_W-1:0] tx_next,
    output logic [DATA_W-1:0] bus_next
);
    localparam logic [SLOT_W-1:0] SIG_IDX = SLOT_W'(SIG_SLOT);

    logic is_frame;
    logic is_sig;
    logic is_pay;

    assign is_frame = (slot == '0);
    assign is_sig   = (slot == SIG_IDX);
    assign is_pay   = !is_frame && !is_sig;

    always_comb begin
        if (is_frame)
            tx_next = fg_byte;
        else if (sel.payload || (sel.remote && is_pay))
            tx_next = rx_byte;
        else
            tx_next = bin_byte;
    end

    always_comb begin
        if (sel.local_ && is_pay)
            bus_next = bin_byte;
        else
            bus_next = rx_byte;
    end
endmodule

// File: rtl/e1_loop_sel.sv
module e1_loop_sel
    import e1lb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SLOT_W   = 5,
    parameter int SIG_SLOT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_stb,
    input  logic [SLOT_W-1:0] ts_num,
    input  logic              frm_sync,
    input  logic              cfg_payload_lb,
    input  logic              cfg_remote_lb,
    input  logic              cfg_local_lb,
    input  logic [DATA_W-1:0] line_rx_byte,
    input  logic [DATA_W-1:0] bus_in_byte,
    input  logic [DATA_W-1:0] fgen_byte,
    output logic [DATA_W-1:0] line_tx_byte,
    output logic [DATA_W-1:0] bus_out_byte,
    output logic              out_stb,
    output logic [SLOT_W-1:0] out_num
);
    lb_state_e         mode_q;
    lb_sel_t           sel;
    logic              boundary;
    logic [DATA_W-1:0] tx_next;
    logic [DATA_W-1:0] bus_next;

    assign boundary = ts_stb && frm_sync;

    e1lb_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .cfg_plb  (cfg_payload_lb),
        .cfg_rmt  (cfg_remote_lb),
        .cfg_lcl  (cfg_local_lb),
        .state_q  (mode_q),
        .sel      (sel)
    );

    e1lb_route #(
        .DATA_W   (DATA_W),
        .SLOT_W   (SLOT_W),
        .SIG_SLOT (SIG_SLOT)
    ) u_route (
        .slot     (ts_num),
        .sel      (sel),
        .rx_byte  (line_rx_byte),
        .bin_byte (bus_in_byte),
        .fg_byte  (fgen_byte),
        .tx_next  (tx_next),
        .bus_next (bus_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_tx_byte <= '0;
            bus_out_byte <= '0;
            out_stb      <= 1'b0;
            out_num      <= '0;
        end else begin
            out_stb <= ts_stb;
            if (ts_stb) begin
                line_tx_byte <= tx_next;
                bus_out_byte <= bus_next;
                out_num      <= ts_num;
            end
        end
    end
endmodule

// File: rtl/e1lb_chk.sv
module e1lb_chk
    import e1lb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SLOT_W   = 5,
    parameter int SIG_SLOT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ts_stb,
    input logic [SLOT_W-1:0] ts_num,
    input logic              frm_sync,
    input logic [DATA_W-1:0] line_rx_byte,
    input logic [DATA_W-1:0] fgen_byte,
    input logic [DATA_W-1:0] line_tx_byte,
    input logic [DATA_W-1:0] bus_out_byte,
    input logic              out_stb,
    input logic [SLOT_W-1:0] out_num,
    input lb_state_e         mode_q
);
    localparam logic [SLOT_W-1:0] SIG_IDX = SLOT_W'(SIG_SLOT);

    AST_STB_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ts_stb |=> (out_stb && out_num == $past(ts_num))); // R2

    AST_TS0_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_stb && ts_num == '0) |=> (line_tx_byte == $past(fgen_byte))); // R4

    AST_SIG_BUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_stb && ts_num == SIG_IDX) |=> (bus_out_byte == $past(line_rx_byte))); // R6

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ts_stb && frm_sync) |=> $stable(mode_q)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_stb |=> (!out_stb && $stable(line_tx_byte) && $stable(bus_out_byte))); // R10
endmodule

bind e1_loop_sel e1lb_chk #(
    .DATA_W   (DATA_W),
    .SLOT_W   (SLOT_W),
    .SIG_SLOT (SIG_SLOT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ts_stb       (ts_stb),
    .ts_num       (ts_num),
    .frm_sync     (frm_sync),
    .line_rx_byte (line_rx_byte),
    .fgen_byte    (fgen_byte),
    .line_tx_byte (line_tx_byte),
    .bus_out_byte (bus_out_byte),
    .out_stb      (out_stb),
    .out_num      (out_num),
    .mode_q       (mode_q)
);

// File: tb/sim_e1_loop_sel.sv
`timescale 1ns/1ps
module sim_e1_loop_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ts_stb = 1'b0;
    logic [4:0] ts_num = '0;
    logic       frm_sync = 1'b0;
    logic       cfg_payload_lb = 1'b0;
    logic       cfg_remote_lb = 1'b0;
    logic       cfg_local_lb = 1'b0;
    logic [7:0] line_rx_byte = '0;
    logic [7:0] bus_in_byte = '0;
    logic [7:0] fgen_byte = '0;
    logic [7:0] line_tx_byte;
    logic [7:0] bus_out_byte;
    logic       out_stb;
    logic [4:0] out_num;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench model of the active configuration
    bit m_plb = 0, m_rmt = 0, m_lcl = 0;
    logic [7:0] m_tx = '0, m_bus = '0;

    always #10 clk = ~clk;

    e1_loop_sel u0 (
        .clk(clk), .rst_n(rst_n), .ts_stb(ts_stb), .ts_num(ts_num), .frm_sync(frm_sync),
        .cfg_payload_lb(cfg_payload_lb), .cfg_remote_lb(cfg_remote_lb), .cfg_local_lb(cfg_local_lb),
        .line_rx_byte(line_rx_byte), .bus_in_byte(bus_in_byte), .fgen_byte(fgen_byte),
        .line_tx_byte(line_tx_byte), .bus_out_byte(bus_out_byte), .out_stb(out_stb), .out_num(out_num)
    );

    function automatic logic [7:0] exp_tx(input logic [4:0] s, input bit plb, input bit rmt,
                                          input logic [7:0] fg, input logic [7:0] rx, input logic [7:0] bi);
        if (s == 0) return fg;
        if (plb) return rx;
        if (rmt && s != 16) return rx;
        return bi;
    endfunction

    function automatic logic [7:0] exp_bus(input logic [4:0] s, input bit lcl,
                                           input logic [7:0] rx, input logic [7:0] bi);
        if (lcl && s != 0 && s != 16) return bi;
        return rx;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // one timeslot; inputs set at a falling edge, result checked at the next one
    task automatic slot(input logic [4:0] s, input bit fs, input bit p, input bit r, input bit l,
                        input string req);
        ts_stb = 1'b1; ts_num = s; frm_sync = fs;
        cfg_payload_lb = p; cfg_remote_lb = r; cfg_local_lb = l;
        line_rx_byte = 8'($urandom); bus_in_byte = 8'($urandom); fgen_byte = 8'($urandom);
        if (fs) begin
            m_plb = p; m_rmt = r; m_lcl = l;
        end
        m_tx  = exp_tx(s, m_plb, m_rmt, fgen_byte, line_rx_byte, bus_in_byte);
        m_bus = exp_bus(s, m_lcl, line_rx_byte, bus_in_byte);
        @(negedge clk);
        check({req, " R2 stb"}, 32'(out_stb), 32'd1);
        check({req, " R2 num"}, 32'(out_num), 32'(s));
        check({req, " tx"}, 32'(line_tx_byte), 32'(m_tx));
        check({req, " bus"}, 32'(bus_out_byte), 32'(m_bus));
    endtask

    task automatic idle();
        ts_stb = 1'b0;
        frm_sync = 1'($urandom);
        cfg_payload_lb = 1'($urandom); cfg_remote_lb = 1'($urandom); cfg_local_lb = 1'($urandom);
        line_rx_byte = 8'($urandom); bus_in_byte = 8'($urandom);
        @(negedge clk);
        check("R10 stb", 32'(out_stb), 32'd0);
        check("R10 tx hold", 32'(line_tx_byte), 32'(m_tx));
        check("R10 bus hold", 32'(bus_out_byte), 32'(m_bus));
    endtask

    task automatic frame(input bit p, input bit r, input bit l, input bit jitter, input string req);
        for (int s = 0; s < 32; s++) begin
            if (s == 0)
                slot(5'(s), 1'b1, p, r, l, req);
            else if (jitter)
                slot(5'(s), 1'b0, 1'($urandom), 1'($urandom), 1'($urandom), {req, " R8 midframe"});
            else
                slot(5'(s), 1'b0, p, r, l, req);
            if (jitter && ($urandom % 8) == 0) idle();
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_e1a0));
        repeat (3) @(negedge clk);
        check("R1 stb in reset", 32'(out_stb), 32'd0);
        check("R1 tx in reset", 32'(line_tx_byte), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stb after reset", 32'(out_stb), 32'd0);
        check("R1 bus after reset", 32'(bus_out_byte), 32'd0);

        // R9: all loopbacks requested, no frame start yet
        for (int s = 5; s < 20; s++) slot(5'(s), 1'b0, 1'b1, 1'b1, 1'b1, "R9 pre-sync");

        frame(0, 0, 0, 0, "R3 R4 normal");
        frame(0, 1, 0, 0, "R5 remote");
        frame(0, 0, 1, 0, "R6 local");
        frame(1, 0, 0, 0, "R7 payload");
        frame(1, 1, 0, 0, "R7 payload over remote");
        frame(1, 0, 1, 0, "R7 R6 payload+local");
        frame(0, 1, 1, 0, "R5 R6 remote+local");

        for (int f = 0; f < 24; f++)
            frame(1'($urandom), 1'($urandom), 1'($urandom), 1'b1, "R8 random");

        idle();
        finish_run();
    end
endmodule